// File: doc/BRIEF.md
# NTSC Color Bit-Pattern Serializer

This block produces a one-bit composite color video stream. The bit clock runs at an integer multiple N of the 3.57954525 MHz color subcarrier, so each subcarrier cycle is exactly N output bits. For every subcarrier cycle the block picks an N-bit on/off pattern and shifts it out.

The pattern's position within the cycle sets the hue, relative to the reference burst. The number of set bits sets the mean level, which is luminance. Together, duty and position also set the strength of the subcarrier component, which is saturation. With N = 4 only 16 phase and amplitude mixes exist. Larger N, up to 128 at about 458 MHz, gives a much finer palette.

A phase counter runs without stopping from reset and is never cleared at line boundaries. Burst and pixel patterns therefore share one phase reference. Upstream logic supplies a color code, a pixel-valid flag, a burst-enable flag and a line-start strobe. It uses the exported phase to present each new code just before a cycle boundary. Sync generation, analog filtering and the pixel source sit outside this block.

Top module: `ntsc_chroma_serializer`

## Requirements
- R1: While rst_n is low, and in the cycle after reset is released, ser_out is 0 and sc_phase is 0.
- R2: sc_phase counts 0, 1, ..., N-1, 0, ... on every clock after reset, and line_start has no effect on it.
- R3: burst_en, pix_valid and pix_code are sampled only at the clock edge where sc_phase wraps from N-1 to 0. A change to them at any other time does not alter the bits shown during the current cycle.
- R4: If burst_en was 1 at the wrap edge, the next cycle outputs 1 for phases 0 to N/2-1 and 0 for the rest, whatever the pixel inputs are. The burst therefore repeats every N bits.
- R5: pix_code[HUE_W-1:0] is the hue index h. A pixel pattern's run of ones begins at phase h*N/2^HUE_W and wraps modulo N.
- R6: pix_code[HUE_W+LVL_W-1:HUE_W] is the level index l. The run holds floor(l*N/(2^LVL_W-1)) ones, so level 0 is all low and the top level is all high.
- R7: The bit output while sc_phase equals p is pattern bit N-1-p, so the pattern is sent most significant bit first, starting at phase 0.
- R8: If burst_en and pix_valid were both 0 at the wrap edge, ser_out is 0 for the whole following cycle.
- R9: A line_start pulse at an edge other than the wrap edge forces ser_out to 0 from the next bit until the next cycle boundary. At the wrap edge the new pattern takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, N times the color subcarrier |
| rst_n | input | 1 | Synchronous reset, active low |
| burst_en | input | 1 | Send the reference burst pattern in the next cycle |
| line_start | input | 1 | Line-start strobe; blanks the rest of the current cycle |
| pix_valid | input | 1 | Active-pixel flag for the next cycle |
| pix_code | input | HUE_W+LVL_W | Pixel color: level index in the upper field, hue index in the lower field |
| ser_out | output | 1 | Serialized one-bit video |
| sc_phase | output | $clog2(N) | Current subcarrier phase, the bit index within the cycle |

## Verification
A wrong phase count shows on sc_phase at the next edge. It also shifts every later pattern boundary, so each following cycle's bits come out misplaced. A bad hue start or duty value corrupts all N bits of the cycle that follows the wrap edge where the code was sampled. Bits shifted in the wrong direction, or a failure to clear on line_start, show within one bit time of the cause. Checking every bit against a model built from the pattern formula catches each of these within one subcarrier cycle.

// File: rtl/csc_pkg.sv
// Shared types for the chroma serializer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package csc_pkg;

    // Source of the pattern loaded for the next subcarrier cycle.
    typedef enum logic [1:0] {
        SRC_BLANK = 2'd0,
        SRC_BURST = 2'd1,
        SRC_PIXEL = 2'd2
    } csc_src_e;

endpackage

// File: rtl/csc_phase_counter.sv
// Free-running modulo-N subcarrier phase counter.
// Assumes: N >= 2. The counter is cleared only by reset, never per line.
module csc_phase_counter #(
    parameter int N   = 16,
    localparam int PHW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [PHW-1:0] phase,
    output logic           wrap
);

    localparam logic [PHW-1:0] LAST = PHW'(N - 1);

    assign wrap = (phase == LAST);

    // Count 0..N-1 and roll over.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (wrap)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // The count stays inside its range.
    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);

    // After the last phase comes phase 0.
    assert_phase_roll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (phase == '0));

    // Phase 0 only follows the last phase.
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> (phase != '0));

endmodule

// File: rtl/csc_pattern_gen.sv
// Builds the N-bit pattern for one subcarrier cycle from the sampled inputs.
// Burst: ones at phases 0..N/2-1. Pixel: a run of duty(level) ones that starts
// at hue*N/2^HUE_W and wraps modulo N. Bit N-1-p belongs to phase p.
// Assumes: N divisible by 2^HUE_W, LVL_W >= 1. Purely combinational.
module csc_pattern_gen
    import csc_pkg::*;
#(
    parameter int N     = 16,
    parameter int HUE_W = 2,
    parameter int LVL_W = 2,
    localparam int CODE_W = HUE_W + LVL_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic              burst,
    input  logic              valid,
    output logic [N-1:0]      pattern
);

    localparam int HUES   = 1 << HUE_W;
    localparam int LEVELS = 1 << LVL_W;
    localparam int HSTEP  = N / HUES;
    localparam int PW     = $clog2(N + 1);

    logic [HUE_W-1:0] hue_f;
    logic [LVL_W-1:0] lvl_f;
    logic [PW-1:0]    start;
    logic [PW-1:0]    duty_tab [LEVELS];
    logic [PW-1:0]    duty_sel;
    logic [N-1:0]     pix_pat;
    logic [N-1:0]     burst_pat;
    csc_src_e         src;

    assign hue_f = code[HUE_W-1:0];
    assign lvl_f = code[CODE_W-1:HUE_W];
    assign start = PW'(hue_f) * PW'(HSTEP);

    // Duty per level, spread evenly from empty to full.
    for (genvar l = 0; l < LEVELS; l++) begin : g_duty
        assign duty_tab[l] = PW'((l * N) / (LEVELS - 1));
    end

    assign duty_sel = duty_tab[lvl_f];

    // One bit per phase: set when the phase lies inside the wrapped run.
    for (genvar p = 0; p < N; p++) begin : g_bit
        logic [PW:0] ofs_raw;
        logic [PW:0] ofs;
        assign ofs_raw = (PW+1)'(p + N) - {1'b0, start};
        assign ofs     = (ofs_raw >= (PW+1)'(N)) ? ofs_raw - (PW+1)'(N) : ofs_raw;
        assign pix_pat[N-1-p]   = (ofs < {1'b0, duty_sel});
        assign burst_pat[N-1-p] = 1'(p < N / 2);
    end

    // Burst wins over pixel; otherwise blank.
    always_comb begin
        if (burst)
            src = SRC_BURST;
        else if (valid)
            src = SRC_PIXEL;
        else
            src = SRC_BLANK;
    end

    // Pick the pattern for the chosen source.
    always_comb begin
        case (src)
            SRC_BURST: pattern = burst_pat;
            SRC_PIXEL: pattern = pix_pat;
            default:   pattern = '0;
        endcase
    end

endmodule

// File: rtl/csc_shifter.sv
// N-bit shift register that sends its content MSB first.
// Load has priority over clear; otherwise the register shifts left and fills with 0.
// Assumes: load is asserted once per N clocks by the phase counter.
module csc_shifter #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clear,
    input  logic [N-1:0] load_val,
    output logic         bit_out
);

    logic [N-1:0] sr;

    assign bit_out = sr[N-1];

    // Load, clear or shift once per bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (load)
            sr <= load_val;
        else if (clear)
            sr <= '0;
        else
            sr <= {sr[N-2:0], 1'b0};
    end

    // A clear outside a load blanks the next bit.
    assert_clear_blanks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !load) |=> !bit_out);

    // A loaded pattern's top bit appears first.
    assert_msb_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bit_out == $past(load_val[N-1])));

endmodule

// File: rtl/ntsc_chroma_serializer.sv
// One-bit composite color serializer. Each subcarrier cycle of N bits carries
// one pattern: burst, pixel or blank, chosen at the phase wrap edge.
// Assumes: clk is N times the color subcarrier. Inputs for a cycle are stable
// at the edge where sc_phase goes from N-1 to 0.
module ntsc_chroma_serializer #(
    parameter int N     = 16,
    parameter int HUE_W = 2,
    parameter int LVL_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     burst_en,
    input  logic                     line_start,
    input  logic                     pix_valid,
    input  logic [HUE_W+LVL_W-1:0]   pix_code,
    output logic                     ser_out,
    output logic [$clog2(N)-1:0]     sc_phase
);

    localparam int CODE_W = HUE_W + LVL_W;
    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    logic         wrap;
    logic [N-1:0] next_pat;

    csc_phase_counter #(.N(N)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (sc_phase),
        .wrap  (wrap)
    );

    csc_pattern_gen #(.N(N), .HUE_W(HUE_W), .LVL_W(LVL_W)) u_pat (
        .code    (pix_code),
        .burst   (burst_en),
        .valid   (pix_valid),
        .pattern (next_pat)
    );

    csc_shifter #(.N(N)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wrap),
        .clear    (line_start),
        .load_val (next_pat),
        .bit_out  (ser_out)
    );

    // Burst opens high at phase 0.
    assert_burst_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && burst_en) |=> ser_out);

    // No burst and no pixel gives a low first bit.
    assert_blank_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !burst_en && !pix_valid) |=> !ser_out);

    // Lowest level gives no ones at all.
    assert_level_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !burst_en && pix_valid && (pix_code[CODE_W-1:HUE_W] == '0)) |=> !ser_out);

    // Top level gives all ones.
    assert_level_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !burst_en && pix_valid && (pix_code[CODE_W-1:HUE_W] == LVL_MAX)) |=> ser_out);

endmodule

// File: tb/ntsc_chroma_serializer_bench.sv
module ntsc_chroma_serializer_bench;

    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       burst_en = 1'b0;
    logic       line_start = 1'b0;
    logic       pix_valid = 1'b0;
    logic [3:0] pix_code = 4'd0;
    logic       ser_out;
    logic [3:0] sc_phase;

    int n_chk = 0;
    int n_bad = 0;
    int wd = 0;
    bit done = 1'b0;

    logic [N-1:0] msr;
    logic [3:0]   mph;
    logic [23:0]  mtag;
    logic [23:0]  ovr = '0;

    always #4 clk = ~clk;

    ntsc_chroma_serializer u_ntsc_chroma_serializer (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_en   (burst_en),
        .line_start (line_start),
        .pix_valid  (pix_valid),
        .pix_code   (pix_code),
        .ser_out    (ser_out),
        .sc_phase   (sc_phase)
    );

    // Pattern from the requirements: R4 burst, R5 hue start, R6 duty, R7 order.
    function automatic logic [N-1:0] exp_pattern(logic b, logic v, logic [3:0] c);
        logic [N-1:0] r = '0;
        int st;
        int d;
        if (b) begin
            for (int p = 0; p < N / 2; p++) r[N-1-p] = 1'b1;
        end else if (v) begin
            st = int'(c[1:0]) * (N / 4);
            d  = (int'(c[3:2]) * N) / 3;
            for (int k = 0; k < d; k++) r[N-1-((st + k) % N)] = 1'b1;
        end
        return r;
    endfunction

    // Reference model of the expected bit stream.
    always @(posedge clk) begin
        if (!rst_n) begin
            mph  <= '0;
            msr  <= '0;
            mtag <= "R1";
        end else begin
            mph <= (mph == 4'(N - 1)) ? 4'd0 : mph + 4'd1;
            if (mph == 4'(N - 1)) begin
                msr <= exp_pattern(burst_en, pix_valid, pix_code);
                if (burst_en)
                    mtag <= "R4";
                else if (!pix_valid)
                    mtag <= "R8";
                else if (pix_code[3:2] == 2'd0 || pix_code[3:2] == 2'd3)
                    mtag <= "R6";
                else
                    mtag <= "R5";
            end else if (line_start) begin
                msr  <= '0;
                mtag <= "R9";
            end else begin
                msr <= {msr[N-2:0], 1'b0};
            end
        end
    end

    // Compare outputs away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (ser_out !== msr[N-1]) begin
                n_bad++;
                $display("FAIL %s ser_out actual=%0b expected=%0b phase=%0d",
                         (ovr != '0) ? ovr : mtag, ser_out, msr[N-1], mph);
            end
            n_chk++;
            if (sc_phase !== mph) begin
                n_bad++;
                $display("FAIL R2 sc_phase actual=%0d expected=%0d", sc_phase, mph);
            end
        end
    end

    task automatic report();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    // Wait for the negedge in the last phase so new inputs meet the wrap edge.
    task automatic align();
        @(negedge clk);
        while (mph != 4'(N - 1)) @(negedge clk);
    endtask

    task automatic play(logic b, logic v, logic [3:0] c, logic [23:0] tag, int ncyc);
        align();
        burst_en  = b;
        pix_valid = v;
        pix_code  = c;
        ovr      <= tag;
        repeat (ncyc * N - 1) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state.
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R4: burst for three cycles, pixel inputs ignored.
        play(1'b1, 1'b1, 4'hF, '0, 3);
        // R7: asymmetric run, hue 1 level 1, ones at phases 4..8.
        play(1'b0, 1'b1, 4'b0101, "R7", 2);
        // R5 and R6: every code.
        for (int c = 0; c < 16; c++) play(1'b0, 1'b1, 4'(c), '0, 1);
        // R8: blank.
        play(1'b0, 1'b0, 4'hF, '0, 1);
        // R3: change inputs mid cycle; the shown pattern stays.
        align();
        pix_valid = 1'b1; pix_code = 4'b1010; burst_en = 1'b0;
        ovr <= "R3";
        repeat (6) @(negedge clk);
        pix_code = 4'b0011; burst_en = 1'b1;
        repeat (8) @(negedge clk);
        burst_en = 1'b0;
        // R9 and R2: line_start mid cycle on a white pixel.
        play(1'b0, 1'b1, 4'hC, '0, 1);
        align();
        pix_valid = 1'b1; pix_code = 4'hC;
        ovr <= '0;
        repeat (5) @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        ovr <= "R2";
        repeat (8) @(negedge clk);
        ovr <= '0;
        // Random mix.
        for (int i = 0; i < 300; i++) begin
            align();
            burst_en  = (($urandom % 8) == 0);
            pix_valid = (($urandom % 4) != 0);
            pix_code  = 4'($urandom);
            ovr      <= '0;
            if (($urandom % 4) == 0) begin
                repeat (1 + ($urandom % 12)) @(negedge clk);
                line_start = 1'b1;
                @(negedge clk);
                line_start = 1'b0;
            end
        end
        align();
        @(negedge clk);
        report();
    end

endmodule